// File: doc/BRIEF.md
# Dual-Mode Single-Wire Trace Serialiser

This block turns a stream of trace bytes into a bit stream on a single output pin. The bytes come from an upstream trace source, such as a stimulus-port stream that does not pass through a frame formatter. Two line codes can be selected at run time. The first is a UART-style NRZ character with a fixed format. The second is a self-clocking Manchester code, which a capture device can decode without knowing the bit rate beforehand. The bit timing comes from the block clock through a programmable divide-by-(prescaler+1) counter.

A small write-only register port sets the prescaler and the line protocol. Every character captures its own copy of both settings when its byte is accepted. A write never disturbs a frame that is already on the wire. The byte input uses a valid/ready handshake, and a busy flag shows that a frame is in progress.

The control state machine has four states:
- `ST_IDLE` waits for a byte. It moves to `ST_START` on acceptance.
- `ST_START` sends the start bit. It moves to `ST_DATA` when the start bit period ends.
- `ST_DATA` shifts out eight bits. When the last bit ends, it moves to `ST_STOP` in NRZ mode or back to `ST_IDLE` in Manchester mode.
- `ST_STOP` sends the NRZ stop bit and then moves to `ST_IDLE`.

Top module: `swt_serialiser`

## Requirements
- R1: After reset the pin is high, `busy` is 0, `in_ready` is 1, the prescaler is 0 and the protocol is NRZ.
- R2: An NRZ character is ten bit periods long. It sends a start bit of 0, then the eight data bits least significant first, then a stop bit of 1. The line is high when idle.
- R3: In Manchester mode each bit occupies two half periods. A 1 is sent high then low, and a 0 is sent low then high. A start bit encoded as 1 comes first, then the eight data bits least significant first, for eighteen half periods in total. The line then returns to its low idle level.
- R4: Writing `cfg_addr`=1 with the value 1 selects Manchester, and with the value 2 selects NRZ. Any other value written there leaves the protocol unchanged.
- R5: Writing `cfg_addr`=0 sets the prescaler P. One NRZ bit, or one Manchester half bit, lasts P+1 clock cycles.
- R6: `in_ready` is 1 only when no frame is in progress. A byte is accepted at a rising edge where `in_valid` and `in_ready` are both 1. `busy` is then 1 for exactly 10(P+1) cycles (NRZ) or 18(P+1) cycles (Manchester), starting in the cycle after acceptance.
- R7: A register write made while a frame is on the wire does not change that frame's code or timing. It applies from the next accepted byte.
- R8: A register write in the same cycle that a byte is accepted applies to the following byte, not to the byte being accepted.
- R9: While idle, the pin sits at the idle level of the currently programmed protocol: high for NRZ, low for Manchester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte available on `in_data` |
| in_ready | output | 1 | Serialiser can take a byte |
| in_data | input | 8 | Trace byte to send |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = prescaler, 1 = protocol |
| cfg_wdata | input | PRESC_W | Register write value |
| serial_out | output | 1 | Serial trace pin |
| busy | output | 1 | Frame in progress |

## Verification
Two functions can fall in the same cycle. A register write can coincide with the acceptance of a byte, and a register write can arrive while a frame is being shifted out. The bench provokes the first by raising `cfg_we` and `in_valid` together. It then checks that the accepted frame keeps the old code while the next frame uses the new one. It provokes the second by writing the protocol or the prescaler partway through a frame. It compares every bit period of that frame against the settings that held at acceptance.

// File: rtl/swt_pkg.sv
package swt_pkg;

    localparam int BYTE_W  = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        PROTO_MAN = 2'd1,
        PROTO_NRZ = 2'd2
    } proto_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } state_e;

    localparam logic ADDR_PRESC = 1'b0;
    localparam logic ADDR_PROTO = 1'b1;

endpackage

// File: rtl/swt_cfg_regs.sv
module swt_cfg_regs
    import swt_pkg::*;
#(
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic               addr,
    input  logic [PRESC_W-1:0] wdata,
    output logic [PRESC_W-1:0] presc_q,
    output proto_e             proto_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
            proto_q <= PROTO_NRZ;
        end else if (we) begin
            if (addr == ADDR_PRESC) begin
                presc_q <= wdata;
            end else if (wdata == PRESC_W'(1)) begin
                proto_q <= PROTO_MAN;
            end else if (wdata == PRESC_W'(2)) begin
                proto_q <= PROTO_NRZ;
            end
        end
    end

endmodule

// File: rtl/swt_bit_timer.sv
module swt_bit_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run) begin
            if (cnt_q == limit) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/swt_frame_fsm.sv
module swt_frame_fsm
    import swt_pkg::*;
#(
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [BYTE_W-1:0]  in_data,
    input  logic [PRESC_W-1:0] cfg_presc,
    input  proto_e             cfg_proto,
    input  logic               tick,
    output logic               in_ready,
    output logic               busy,
    output logic               serial_out,
    output logic               timer_clear,
    output logic               timer_run,
    output logic [PRESC_W-1:0] frame_presc,
    output proto_e             frame_proto
);

    localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(BYTE_W - 1);

    state_e               state_q, state_d;
    logic [BYTE_W-1:0]    shift_q;
    logic [BIT_IDX_W-1:0] bit_q;
    logic                 half_q;
    logic                 man;
    logic                 accept;
    logic                 bit_end;
    logic                 last_unit;

    assign man       = (frame_proto == PROTO_MAN);
    assign accept    = in_valid && (state_q == ST_IDLE);
    assign bit_end   = man ? half_q : 1'b1;
    assign last_unit = (bit_q == LAST_BIT) && bit_end;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)             state_d = ST_START;
            ST_START: if (tick && bit_end)    state_d = ST_DATA;
            ST_DATA:  if (tick && last_unit)  state_d = man ? ST_IDLE : ST_STOP;
            ST_STOP:  if (tick)               state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // frame datapath: per-character settings, shifter, bit and half counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q     <= '0;
            bit_q       <= '0;
            half_q      <= 1'b0;
            frame_presc <= '0;
            frame_proto <= PROTO_NRZ;
        end else if (accept) begin
            shift_q     <= in_data;
            bit_q       <= '0;
            half_q      <= 1'b0;
            frame_presc <= cfg_presc;
            frame_proto <= cfg_proto;
        end else if (tick) begin
            if (man) begin
                half_q <= ~half_q;
            end
            if ((state_q == ST_DATA) && bit_end && (bit_q != LAST_BIT)) begin
                bit_q   <= bit_q + 1'b1;
                shift_q <= shift_q >> 1;
            end
        end
    end

    // outputs
    always_comb begin
        in_ready    = (state_q == ST_IDLE);
        busy        = (state_q != ST_IDLE);
        timer_run   = (state_q != ST_IDLE);
        timer_clear = accept;
        serial_out  = 1'b1;
        unique case (state_q)
            ST_IDLE:  serial_out = (cfg_proto == PROTO_NRZ);
            ST_START: serial_out = man ? ~half_q : 1'b0;
            ST_DATA:  serial_out = man ? (shift_q[0] ^ half_q) : shift_q[0];
            ST_STOP:  serial_out = 1'b1;
            default:  serial_out = 1'b1;
        endcase
    end

endmodule

// File: rtl/swt_serialiser.sv
module swt_serialiser
    import swt_pkg::*;
#(
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [7:0]         in_data,
    input  logic               cfg_we,
    input  logic               cfg_addr,
    input  logic [PRESC_W-1:0] cfg_wdata,
    output logic               serial_out,
    output logic               busy
);

    logic [PRESC_W-1:0] cfg_presc;
    proto_e             cfg_proto;
    logic [PRESC_W-1:0] frame_presc;
    proto_e             frame_proto;
    logic               tick;
    logic               timer_clear;
    logic               timer_run;

    swt_cfg_regs #(.PRESC_W(PRESC_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .presc_q (cfg_presc),
        .proto_q (cfg_proto)
    );

    swt_bit_timer #(.CNT_W(PRESC_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clear),
        .run   (timer_run),
        .limit (frame_presc),
        .tick  (tick)
    );

    swt_frame_fsm #(.PRESC_W(PRESC_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .cfg_presc   (cfg_presc),
        .cfg_proto   (cfg_proto),
        .tick        (tick),
        .in_ready    (in_ready),
        .busy        (busy),
        .serial_out  (serial_out),
        .timer_clear (timer_clear),
        .timer_run   (timer_run),
        .frame_presc (frame_presc),
        .frame_proto (frame_proto)
    );

endmodule

// File: rtl/swt_sva.sv
module swt_sva #(
    parameter int PRESC_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               cfg_we,
    input logic               cfg_addr,
    input logic [PRESC_W-1:0] cfg_wdata,
    input logic               serial_out,
    input logic               busy,
    input logic [1:0]         cfg_proto,
    input logic [1:0]         frame_proto
);

    // R6
    accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);

    // R6
    no_ready_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);

    // R2
    nrz_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && cfg_proto == 2'd2) |=> !serial_out);

    // R3
    man_start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && cfg_proto == 2'd1) |=> serial_out);

    // R7
    frame_code_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(frame_proto));

    // R9
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (serial_out == (cfg_proto == 2'd2)));

    // R4
    bad_proto_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr && cfg_wdata != PRESC_W'(1) && cfg_wdata != PRESC_W'(2))
        |=> $stable(cfg_proto));

endmodule

bind swt_serialiser swt_sva #(.PRESC_W(PRESC_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .serial_out  (serial_out),
    .busy        (busy),
    .cfg_proto   (cfg_proto),
    .frame_proto (frame_proto)
);

// File: tb/tb_swt_serialiser.sv
module tb_swt_serialiser;

    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          cfg_we = 1'b0;
    logic          cfg_addr = 1'b0;
    logic [PW-1:0] cfg_wdata = '0;
    wire           in_ready;
    wire           serial_out;
    wire           busy;

    int checks = 0;
    int failures = 0;
    int m_presc = 0;
    int m_proto = 2;

    // fields: protocol [13:12], prescaler [11:8], byte [7:0]
    localparam logic [13:0] VEC [8] = '{
        {2'd2, 4'd0, 8'h55},
        {2'd2, 4'd3, 8'hA3},
        {2'd2, 4'd1, 8'h00},
        {2'd2, 4'd2, 8'hFF},
        {2'd1, 4'd0, 8'h5A},
        {2'd1, 4'd2, 8'h81},
        {2'd1, 4'd1, 8'h00},
        {2'd1, 4'd3, 8'hFF}
    };

    swt_serialiser #(.PRESC_W(PW)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .serial_out (serial_out),
        .busy       (busy)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_level(input int proto, input logic [7:0] d, input int unit);
        bit v;
        if (proto == 1) begin
            v = (unit / 2 == 0) ? 1'b1 : d[unit/2 - 1];
            return (unit % 2 == 0) ? v : ~v;
        end
        if (unit == 0) return 1'b0;
        if (unit == 9) return 1'b1;
        return d[unit - 1];
    endfunction

    task automatic model_write(input bit a, input int v);
        if (a == 1'b0) m_presc = v;
        else if (v == 1 || v == 2) m_proto = v;
    endtask

    task automatic cfg_write(input bit a, input int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = PW'(v);
        model_write(a, v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // wr_at: -1 none, -2 write in the acceptance cycle, >=0 write at that frame cycle
    task automatic send_byte(input logic [7:0] d, input int wr_at, input bit wa,
                             input int wv, input string req);
        int fp, fprs, len, bad_line, bad_hs, first_i, first_act, first_exp;
        bad_line = 0; bad_hs = 0; first_i = -1; first_act = 0; first_exp = 0;
        @(negedge clk);
        in_valid = 1'b1; in_data = d;
        fp = m_proto; fprs = m_presc;
        if (wr_at == -2) begin
            cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = PW'(wv);
            model_write(wa, wv);
        end
        len = ((fp == 1) ? 18 : 10) * (fprs + 1);
        @(posedge clk);
        for (int i = 0; i <= len; i++) begin
            @(negedge clk);
            if (i < len) begin
                if (serial_out !== exp_level(fp, d, i / (fprs + 1))) begin
                    if (bad_line == 0) begin
                        first_i = i; first_act = serial_out;
                        first_exp = exp_level(fp, d, i / (fprs + 1));
                    end
                    bad_line++;
                end
                if (busy !== 1'b1 || in_ready !== 1'b0) bad_hs++;
            end else begin
                chk(busy === 1'b0 && in_ready === 1'b1, {req, " R6 R5"},
                    "busy/ready after frame end", {busy, in_ready}, 1);
                chk(serial_out === (m_proto == 2), {req, " R9"},
                    "idle level after frame", serial_out, (m_proto == 2));
            end
            if (i == 0) begin
                in_valid = 1'b0;
                if (wr_at == -2) cfg_we = 1'b0;
            end
            if (wr_at >= 0 && i == wr_at) begin
                cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = PW'(wv);
                model_write(wa, wv);
            end
            if (wr_at >= 0 && i == wr_at + 1) cfg_we = 1'b0;
        end
        if (bad_line != 0)
            $display("FAIL %s R5 line at frame cycle %0d actual=%0d expected=%0d",
                     req, first_i, first_act, first_exp);
        chk(bad_line == 0, {req, " R5"}, "line mismatches in frame", bad_line, 0);
        chk(bad_hs == 0, {req, " R6"}, "busy/ready wrong during frame", bad_hs, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not complete actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(serial_out === 1'b1, "R1", "pin after reset", serial_out, 1);
        chk(busy === 1'b0, "R1", "busy after reset", busy, 0);
        chk(in_ready === 1'b1, "R1", "ready after reset", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: default prescaler 0 and NRZ code
        send_byte(8'hC3, -1, 1'b0, 0, "R1 R2");

        // vector table: R2 for NRZ rows, R3 for Manchester rows
        for (int k = 0; k < 8; k++) begin
            cfg_write(1'b1, int'(VEC[k][13:12]));
            cfg_write(1'b0, int'(VEC[k][11:8]));
            send_byte(VEC[k][7:0], -1, 1'b0, 0, (VEC[k][13:12] == 2'd1) ? "R3" : "R2");
        end

        // R4: unsupported protocol values are ignored
        cfg_write(1'b1, 2);
        cfg_write(1'b0, 1);
        cfg_write(1'b1, 3);
        @(negedge clk);
        chk(serial_out === 1'b1, "R4", "idle level after writing 3", serial_out, 1);
        send_byte(8'h96, -1, 1'b0, 0, "R4");
        cfg_write(1'b1, 1);
        cfg_write(1'b1, 0);
        @(negedge clk);
        chk(serial_out === 1'b0, "R4", "idle level after writing 0", serial_out, 0);
        send_byte(8'h3C, -1, 1'b0, 0, "R4");

        // R7: protocol change in the middle of a Manchester frame
        send_byte(8'hC6, 7, 1'b1, 2, "R7");
        send_byte(8'h6C, -1, 1'b0, 0, "R7");
        // R7: prescaler change in the middle of an NRZ frame
        send_byte(8'h21, 3, 1'b0, 4, "R7");
        send_byte(8'hE7, -1, 1'b0, 0, "R7");

        // R8: write in the acceptance cycle applies to the following byte
        cfg_write(1'b0, 2);
        send_byte(8'h4B, -2, 1'b1, 1, "R8");
        send_byte(8'hB4, -1, 1'b0, 0, "R8");
        send_byte(8'h0F, -2, 1'b0, 0, "R8");
        send_byte(8'hF0, -1, 1'b0, 0, "R8");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule